// File: doc/BRIEF.md
# Configuration Read Master for a Single Board-Level PCI Target

This block is a small bus master for a board that has no host bridge. Its only job is to read the configuration header of one PCI target. After system reset it first holds the target in reset for a fixed number of clocks, then releases it. Once the target is released and the block is idle, a one-clock start pulse together with a dword register index launches a single-dword Type 0 configuration read.

The target is selected by one hard-wired upper AD line. That line is raised during the address phase and is wired on the board to the target's IDSEL input. When the access ends, the block pulses `done` for one clock and presents either the 32-bit read data or an error flag.

Three endings are possible:
- **Data:** the target asserts TRDY# and the block captures AD.
- **No claim:** the target never claims the cycle with DEVSEL#, and the block performs a master abort.
- **Retry:** the target signals STOP# without TRDY#. The block reissues the same access up to a parameterised number of times, then gives up and reports an error.

Top module: `cfg_rd_master`

## Requirements
- R1: After `rst_n` rises, `tgt_rst_n` stays low through the first RST_HOLD rising edges and goes high on edge RST_HOLD+1 (default RST_HOLD=16). Until then `ready` is low and no address phase occurs.
- R2: A `start` pulse is accepted only while `ready` is high. A pulse sent while the target is still in reset, or while a transaction is running, starts nothing.
- R3: An address phase holds `frame_n` low for exactly one clock. During that clock `irdy_n` is high, `ad_oe` is high and `cbe_n` equals 4'b1010.
- R4: The address word has bit IDSEL_BIT set (default 16), the register index on AD[5:2], and every other bit zero, including AD[1:0]=2'b00 and the function number AD[10:8].
- R5: In the clock after the address phase, `frame_n` is high, `irdy_n` is low, `ad_oe` is low (turnaround) and `cbe_n` is 4'b0000. `irdy_n` stays low until the data phase ends.
- R6: On the first rising edge where `trdy_n` is low while `irdy_n` is low, `ad_in` is captured into `rdata` and `err` is cleared. TRDY# wins even if `stop_n` is also low. `done` is high in the following clock, which is k+1 clocks after the address clock when the data edge is the k-th edge after it.
- R7: If `devsel_n` is not sampled low on any of the first DEVSEL_LIM edges after the address clock (default 5), the block ends the cycle with `err`=1 and `rdata`=32'hFFFFFFFF. In that case `done` rises 6 clocks after the address clock.
- R8: When `stop_n` is sampled low with `trdy_n` high, the block releases `irdy_n` for one idle clock and repeats the identical address phase, for at most RETRY_MAX retries (default 3). One more stop after that ends the access with `err`=1 and `rdata`=32'hFFFFFFFF.
- R9: `done` is a single-clock pulse, after which `irdy_n` is high. `rdata` and `err` hold their values until the next transaction ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| start | input | 1 | Request one configuration read |
| reg_idx | input | IDX_W (4) | Dword index into the configuration header |
| ready | output | 1 | Target released and state machine idle |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Last access was aborted or gave up retrying |
| rdata | output | 32 | Last read data, all ones on error |
| tgt_rst_n | output | 1 | Active-low reset to the target |
| ad_out | output | 32 | Value the master drives on AD |
| ad_oe | output | 1 | Master drives AD |
| ad_in | input | 32 | Sampled AD lines |
| cbe_n | output | 4 | Command / byte enables, active low |
| frame_n | output | 1 | FRAME#, active low |
| irdy_n | output | 1 | IRDY#, active low |
| devsel_n | input | 1 | DEVSEL# from the target |
| trdy_n | input | 1 | TRDY# from the target |
| stop_n | input | 1 | STOP# from the target |

## Verification
A wrong state register shows on the bus pins in the very next clock. Possible symptoms are a second FRAME# clock, IRDY# asserted together with FRAME#, or AD still driven in the turnaround clock.

A miscounted DEVSEL window or retry counter shows as `done` arriving a clock early or late against the address clock. It can also show as the wrong number of address phases per request, or an error reported while data was offered.

A wrong capture edge shows in `rdata`, because the bench puts a different value on AD in every clock before the TRDY# clock.

// File: rtl/cfg_rd_pkg.sv
package cfg_rd_pkg;

  localparam logic [3:0] CMD_CFG_READ = 4'b1010;
  localparam logic [3:0] BE_ALL_LANES = 4'b0000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_GAP,
    ST_FIN
  } cfg_state_e;

  // Type 0 address word: one select bit, dword index on [7:2], function 0, [1:0]=00
  function automatic logic [31:0] cfg_addr_word(input logic [5:0] idx,
                                                input int unsigned sel_bit);
    logic [31:0] w;
    w = 32'(1) << sel_bit;
    w = w | {24'd0, idx, 2'b00};
    return w;
  endfunction

  function automatic logic [31:0] fail_word();
    return '1;
  endfunction

endpackage

// File: rtl/cfg_rd_rstseq.sv
module cfg_rd_rstseq #(
  parameter int unsigned HOLD_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tgt_rst_n,
  output logic released
);

  localparam int CW = $clog2(HOLD_CYC + 1) + 1;

  logic [CW-1:0] hold_cnt;
  logic          hold_done;

  assign hold_done = (hold_cnt == CW'(HOLD_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt  <= '0;
      tgt_rst_n <= 1'b0;
    end else begin
      if (!hold_done) hold_cnt <= hold_cnt + 1'b1;
      tgt_rst_n <= hold_done;
    end
  end

  assign released = tgt_rst_n;

  AST_TGT_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_rst_n |=> tgt_rst_n) else $error("target reset reasserted"); // R1

  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    hold_cnt <= CW'(HOLD_CYC)) else $error("hold counter overran"); // R1

endmodule

// File: rtl/cfg_rd_fsm.sv
module cfg_rd_fsm
  import cfg_rd_pkg::*;
#(
  parameter int unsigned DEVSEL_LIM = 5,
  parameter int unsigned RETRY_MAX  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       released,
  input  logic       start,
  input  logic       devsel_n,
  input  logic       trdy_n,
  input  logic       stop_n,
  output cfg_state_e state,
  output logic       ready,
  output logic       ev_accept,
  output logic       ev_data,
  output logic       ev_fail
);

  localparam int WW = $clog2(DEVSEL_LIM) + 1;
  localparam int RW = $clog2(RETRY_MAX + 1) + 1;

  logic [WW-1:0] win_cnt;
  logic [RW-1:0] retry_cnt;
  logic          claimed;

  // named internal events
  logic in_data, claim_now, ev_stop, ev_retry, ev_giveup, ev_abort, win_last;

  assign ready     = released && (state == ST_IDLE);
  assign ev_accept = ready && start;
  assign in_data   = (state == ST_DATA);
  assign claim_now = claimed || !devsel_n;
  assign win_last  = (win_cnt == WW'(DEVSEL_LIM - 1));
  assign ev_data   = in_data && !trdy_n;
  assign ev_stop   = in_data && trdy_n && !stop_n;
  assign ev_retry  = ev_stop && (retry_cnt < RW'(RETRY_MAX));
  assign ev_giveup = ev_stop && !ev_retry;
  assign ev_abort  = in_data && trdy_n && stop_n && !claim_now && win_last;
  assign ev_fail   = ev_abort || ev_giveup;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      win_cnt   <= '0;
      retry_cnt <= '0;
      claimed   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (ev_accept) begin
            state     <= ST_ADDR;
            retry_cnt <= '0;
          end
        end
        ST_ADDR: begin
          state   <= ST_DATA;
          win_cnt <= '0;
          claimed <= 1'b0;
        end
        ST_DATA: begin
          claimed <= claim_now;
          if (!claim_now && !win_last) win_cnt <= win_cnt + 1'b1;
          if (ev_data || ev_fail) begin
            state <= ST_FIN;
          end else if (ev_retry) begin
            state     <= ST_GAP;
            retry_cnt <= retry_cnt + 1'b1;
          end
        end
        ST_GAP:  state <= ST_ADDR;
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    win_cnt < WW'(DEVSEL_LIM)) else $error("devsel window overran"); // R7

  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    retry_cnt <= RW'(RETRY_MAX)) else $error("retry count overran"); // R8

  AST_RETRY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_retry |=> (state == ST_GAP) ##1 (state == ST_ADDR)) else $error("retry path wrong"); // R8

  AST_FIN_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FIN) |=> (state == ST_IDLE)) else $error("fin not followed by idle"); // R9

  AST_IDLE_UNTIL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !released |-> (state == ST_IDLE)) else $error("activity during target reset"); // R1

endmodule

// File: rtl/cfg_rd_dpath.sv
module cfg_rd_dpath
  import cfg_rd_pkg::*;
#(
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned IDSEL_BIT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_accept,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic             ev_data,
  input  logic             ev_fail,
  input  logic [31:0]      ad_in,
  output logic [31:0]      addr_word,
  output logic [31:0]      rdata,
  output logic             err
);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      if (ev_accept) idx_q <= reg_idx;
      if (ev_data) begin
        rdata <= ad_in;
        err   <= 1'b0;
      end else if (ev_fail) begin
        rdata <= fail_word();
        err   <= 1'b1;
      end
    end
  end

  assign addr_word = cfg_addr_word(6'(idx_q), IDSEL_BIT);

  AST_ONE_ENDING: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_data && ev_fail)) else $error("data and failure together"); // R6

  AST_ERR_MEANS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fail |=> (err && rdata == 32'hFFFF_FFFF)) else $error("error without all ones"); // R7

endmodule

// File: rtl/cfg_rd_master.sv
module cfg_rd_master
  import cfg_rd_pkg::*;
#(
  parameter int unsigned IDX_W      = 4,
  parameter int unsigned IDSEL_BIT  = 16,
  parameter int unsigned RST_HOLD   = 16,
  parameter int unsigned DEVSEL_LIM = 5,
  parameter int unsigned RETRY_MAX  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] reg_idx,
  output logic             ready,
  output logic             done,
  output logic             err,
  output logic [31:0]      rdata,
  output logic             tgt_rst_n,
  output logic [31:0]      ad_out,
  output logic             ad_oe,
  input  logic [31:0]      ad_in,
  output logic [3:0]       cbe_n,
  output logic             frame_n,
  output logic             irdy_n,
  input  logic             devsel_n,
  input  logic             trdy_n,
  input  logic             stop_n
);

  cfg_state_e  state;
  logic        released;
  logic        ev_accept, ev_data, ev_fail;
  logic [31:0] addr_word;

  cfg_rd_rstseq #(.HOLD_CYC(RST_HOLD)) rstseq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tgt_rst_n (tgt_rst_n),
    .released  (released)
  );

  cfg_rd_fsm #(.DEVSEL_LIM(DEVSEL_LIM), .RETRY_MAX(RETRY_MAX)) fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .released  (released),
    .start     (start),
    .devsel_n  (devsel_n),
    .trdy_n    (trdy_n),
    .stop_n    (stop_n),
    .state     (state),
    .ready     (ready),
    .ev_accept (ev_accept),
    .ev_data   (ev_data),
    .ev_fail   (ev_fail)
  );

  cfg_rd_dpath #(.IDX_W(IDX_W), .IDSEL_BIT(IDSEL_BIT)) dpath_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_accept (ev_accept),
    .reg_idx   (reg_idx),
    .ev_data   (ev_data),
    .ev_fail   (ev_fail),
    .ad_in     (ad_in),
    .addr_word (addr_word),
    .rdata     (rdata),
    .err       (err)
  );

  // bus pins decoded from the state register
  assign frame_n = (state != ST_ADDR);
  assign irdy_n  = (state != ST_DATA);
  assign ad_oe   = (state == ST_ADDR);
  assign ad_out  = ad_oe ? addr_word : '0;
  assign cbe_n   = (state == ST_ADDR) ? CMD_CFG_READ : BE_ALL_LANES;
  assign done    = (state == ST_FIN);

  AST_FRAME_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> frame_n) else $error("frame longer than one clock"); // R3

  AST_ADDR_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |-> (cbe_n == 4'b1010 && ad_oe && irdy_n)) else $error("bad address phase"); // R3

  AST_TYPE0_FMT: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |-> (ad_out[1:0] == 2'b00 && ad_out[10:8] == 3'b000 &&
                  $countones(ad_out[31:11]) == 1)) else $error("bad type 0 word"); // R4

  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> (!irdy_n && !ad_oe && cbe_n == 4'b0000)) else $error("bad turnaround"); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one clock"); // R9

  AST_NO_CYCLE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_rst_n |-> frame_n) else $error("cycle during target reset"); // R1

endmodule

// File: tb/cfg_rd_master_tb_top.sv
module cfg_rd_master_tb_top;

  localparam int unsigned IDX_W      = 4;
  localparam int unsigned IDSEL_BIT  = 16;
  localparam int unsigned RST_HOLD   = 16;
  localparam int unsigned DEVSEL_LIM = 5;
  localparam int unsigned RETRY_MAX  = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic [IDX_W-1:0] reg_idx;
  logic             ready, done, err, tgt_rst_n, ad_oe, frame_n, irdy_n;
  logic [31:0]      rdata, ad_out, ad_in;
  logic [3:0]       cbe_n;
  logic             devsel_n, trdy_n, stop_n;

  always #10 clk = ~clk;

  cfg_rd_master #(
    .IDX_W(IDX_W), .IDSEL_BIT(IDSEL_BIT), .RST_HOLD(RST_HOLD),
    .DEVSEL_LIM(DEVSEL_LIM), .RETRY_MAX(RETRY_MAX)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .reg_idx(reg_idx),
    .ready(ready), .done(done), .err(err), .rdata(rdata),
    .tgt_rst_n(tgt_rst_n), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .cbe_n(cbe_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // target model settings
  int          t_dv = 1, t_tr = 1, t_stops = 0, t_stop_edge = 1;
  bit          t_noresp = 0, t_both = 0;
  logic [31:0] t_data = '0;
  // target observations
  int          n_addr = 0, addr_cyc = 0;
  logic [31:0] cap_ad;
  logic [3:0]  cap_cbe;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input int idx);
    return (32'h1 << IDSEL_BIT) + 32'(idx * 4);
  endfunction

  task automatic check_turn();
    #5;
    chk(frame_n == 1'b1 && irdy_n == 1'b0, "R5", "frame/irdy after addr",
        {30'd0, frame_n, irdy_n}, 32'h2);
    chk(ad_oe == 1'b0 && cbe_n == 4'b0000, "R5", "oe/cbe in turnaround",
        {27'd0, ad_oe, cbe_n}, 32'h0);
  endtask

  // behavioural target
  initial begin
    devsel_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1; ad_in = '0;
    forever begin
      @(negedge clk);
      if (frame_n === 1'b0) begin
        n_addr++;
        addr_cyc = cyc;
        cap_ad   = ad_out;
        cap_cbe  = cbe_n;
        chk(irdy_n == 1'b1 && ad_oe == 1'b1, "R3", "irdy/oe in addr",
            {30'd0, irdy_n, ad_oe}, 32'h3);
        @(posedge clk); #1;
        if (t_noresp) begin
          check_turn();
        end else begin
          automatic bit stopping = (t_stops > 0);
          for (int k = 1; k <= 40; k++) begin
            devsel_n = !(k >= t_dv);
            if (stopping) begin
              trdy_n = 1'b1;
              stop_n = !(k == t_stop_edge);
              ad_in  = 32'hBAD0_0000 | 32'(k);
            end else begin
              trdy_n = !(k == t_tr);
              stop_n = !(t_both && k == t_tr);
              ad_in  = (k == t_tr) ? t_data : (32'h5EED_0000 | 32'(k));
            end
            if (k == 1) check_turn();
            @(posedge clk); #1;
            if (stopping && k == t_stop_edge) break;
            if (!stopping && k == t_tr) break;
          end
          if (stopping) t_stops--;
        end
        devsel_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1; ad_in = '0;
      end
    end
  end

  task automatic run_txn(input int idx, input int dv, input int tr,
                         input logic [31:0] data, input int stops,
                         input int stop_edge, input bit noresp,
                         input bit both, input bit poke);
    int a0, done_cyc, w, attempts, lat;
    bit fail;
    t_dv = dv; t_tr = tr; t_data = data; t_stops = stops;
    t_stop_edge = stop_edge; t_noresp = noresp; t_both = both;
    w = 0;
    @(negedge clk);
    while (!ready && w < 100) begin @(negedge clk); w++; end
    a0 = n_addr;
    start = 1'b1; reg_idx = IDX_W'(idx);
    @(negedge clk);
    start = 1'b0;
    w = 0;
    while (!done && w < 300) begin
      if (poke && w == 2) begin
        start = 1'b1; reg_idx = IDX_W'(idx ^ 5);
      end else start = 1'b0;
      @(negedge clk); w++;
    end
    start = 1'b0;
    done_cyc = cyc;
    fail = noresp || (stops > int'(RETRY_MAX));
    attempts = noresp ? 1 : (fail ? int'(RETRY_MAX) + 1 : stops + 1);
    lat = noresp ? 6 : (fail ? stop_edge + 1 : tr + 1);
    chk(done == 1'b1, fail ? "R7" : "R6", "done seen", 32'(done), 32'h1);
    chk(rdata == (fail ? 32'hFFFF_FFFF : data), noresp ? "R7" : (fail ? "R8" : "R6"),
        "rdata", rdata, fail ? 32'hFFFF_FFFF : data);
    chk(err == fail, noresp ? "R7" : (fail ? "R8" : "R6"), "err", 32'(err), 32'(fail));
    chk(n_addr - a0 == attempts, "R8", "address phases", 32'(n_addr - a0), 32'(attempts));
    chk(cap_ad == exp_addr(idx), "R4", "address word", cap_ad, exp_addr(idx));
    chk(cap_cbe == 4'b1010, "R3", "command", 32'(cap_cbe), 32'hA);
    chk(done_cyc - addr_cyc == lat, noresp ? "R7" : "R6", "done latency",
        32'(done_cyc - addr_cyc), 32'(lat));
    @(negedge clk);
    chk(done == 1'b0 && irdy_n == 1'b1, "R9", "done pulse end / irdy",
        {30'd0, done, irdy_n}, 32'h1);
    t_stops = 0;
    if (poke) begin
      for (int i = 0; i < 5; i++) begin
        chk(frame_n == 1'b1, "R2", "no cycle from busy start", 32'(frame_n), 32'h1);
        @(negedge clk);
      end
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd20417));
    rst_n = 1'b0; start = 1'b0; reg_idx = '0;
    repeat (3) @(negedge clk);
    chk(tgt_rst_n == 1'b0 && ready == 1'b0, "R1", "reset state", {30'd0, tgt_rst_n, ready}, 32'h0);
    chk(frame_n && irdy_n && !ad_oe && !done, "R1", "bus idle in reset",
        {28'd0, frame_n, irdy_n, ad_oe, done}, 32'hC);
    rst_n = 1'b1;
    for (int k = 1; k <= int'(RST_HOLD); k++) begin
      start = (k == 3);
      @(negedge clk);
    end
    start = 1'b0;
    chk(tgt_rst_n == 1'b0 && ready == 1'b0, "R1", "still in reset at edge HOLD",
        {30'd0, tgt_rst_n, ready}, 32'h0);
    @(negedge clk);
    chk(tgt_rst_n == 1'b1 && ready == 1'b1, "R1", "released at edge HOLD+1",
        {30'd0, tgt_rst_n, ready}, 32'h3);
    chk(n_addr == 0, "R2", "start during target reset ignored", 32'(n_addr), 32'h0);

    run_txn(0, 1, 1, 32'h1234_5678, 0, 1, 0, 0, 0);          // R6 fast
    run_txn(15, 3, 4, 32'hCAFE_F00D, 0, 1, 0, 0, 0);         // R4 top index
    run_txn(7, 5, 5, 32'h0BAD_BEEF, 0, 1, 0, 0, 0);          // R7 boundary claim
    run_txn(2, 1, 1, 32'h0, 0, 1, 1, 0, 0);                  // R7 master abort
    run_txn(4, 2, 2, 32'hA5A5_5A5A, 1, 2, 0, 0, 0);          // R8 single retry
    run_txn(9, 1, 3, 32'h7777_1111, int'(RETRY_MAX), 1, 0, 0, 0);     // R8 max retries
    run_txn(11, 2, 2, 32'h0, int'(RETRY_MAX) + 1, 3, 0, 0, 0);        // R8 give up
    run_txn(5, 2, 3, 32'h3C3C_C3C3, 0, 1, 0, 1, 0);          // R6 trdy beats stop
    run_txn(6, 2, 4, 32'h600D_600D, 0, 1, 0, 0, 1);          // R2 busy start ignored

    held = rdata;
    repeat (6) @(negedge clk);
    chk(rdata == held && err == 1'b0, "R9", "rdata holds", rdata, held);

    for (int i = 0; i < 40; i++) begin
      automatic int dv = 1 + int'($urandom % 5);
      automatic int tr = dv + int'($urandom % 3);
      automatic int st = int'($urandom % 3);
      automatic int se = dv + int'($urandom % 2);
      automatic bit nr = (($urandom % 8) == 0);
      run_txn(int'($urandom % 16), dv, tr, $urandom, st, se, nr, 0, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule